// File: doc/BRIEF.md
# Configuration DMA Launch Controller

This block sits in front of a DMA engine that moves configuration data. Software programs four setup registers through a small write/read port: source address, destination address, source length and destination length. Writing the destination length is the trigger. If the setup is valid, the controller issues a one-cycle start pulse to the engine and holds a busy flag until the transfer finishes. A setup is valid when the first three registers were written in order, every address and length is a multiple of 64 bytes, and no transfer is running.

The engine reports two completion events. One says the DMA moves have finished. The other says the data has been delivered to the configuration port. Each event sets its own sticky status bit. A rejected launch sets a third sticky bit for errors. Software can poll the status register, or it can unmask bits so that an interrupt output follows them. Status bits clear when a 1 is written to them. The bus master and the data path are outside this block. The engine is represented only by its start and done signals.

Top module: `dma_launch_ctrl`

## Requirements
- R1: Offsets 0 (source address), 1 (destination address), 2 (source length) and 3 (destination length) store the written data word. Each reads back the last value written to it.
- R2: A valid launch drives `eng_start_o` high for exactly the one cycle after the offset-3 write. It presents the four register values on the engine outputs and sets busy, which reads as status bit 3.
- R3: A launch is valid only if offsets 0, 1 and 2 were written in that order, with nothing out of order in between, since the previous offset-3 write. Otherwise the offset-3 write sets error bit 2 and does not start.
- R4: The six low bits of all four values must be zero, where the destination length is the value being written. Otherwise the write sets error bit 2 and does not start.
- R5: An offset-3 write while busy sets error bit 2, gives no start, and leaves the running transfer pending.
- R6: Status bit 0 (DMA done) is set by `dma_done_i`, and status bit 1 (port done) is set by `port_done_i`. Each bit is set only while that event is still pending for the current transfer. A done pulse when its event is not pending has no effect.
- R7: Busy stays set until both done events of the transfer have arrived, in either order or in the same cycle. It clears in the cycle after the later one.
- R8: A write to offset 4 clears every status bit whose data bit is 1 and leaves the others unchanged. Status bits never clear otherwise, except at reset. A set that arrives in the same cycle as a clear wins.
- R9: `irq_o` is high whenever any of status bits 0 to 2 is set while the matching bit of the mask register (offset 5, bits 2:0) is 1.
- R10: After reset, every register, the status, busy, `eng_start_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write offset |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read offset |
| rd_data_o | output | DATA_W | Read data for `rd_addr_i` (combinational) |
| eng_start_o | output | 1 | One-cycle launch pulse to the engine |
| eng_src_o | output | DATA_W | Source address for the engine |
| eng_dst_o | output | DATA_W | Destination address for the engine |
| eng_src_len_o | output | DATA_W | Source length for the engine |
| eng_dst_len_o | output | DATA_W | Destination length for the engine |
| dma_done_i | input | 1 | Engine pulse: DMA moves finished |
| port_done_i | input | 1 | Engine pulse: data delivered to the port |
| irq_o | output | 1 | Masked OR of the status bits |

## Verification
A write or done pulse that the design samples at one rising edge shows up in the status register, busy and the start output straight after that edge. Read data is combinational from those registers, and `irq_o` is combinational from status and mask. So the bench drives inputs on the falling edge, waits one rising edge, and samples at the following falling edge. The start pulse is due in that same half-cycle window. A monitor samples it there against a queue of expected launches. Any start pulse that arrives with the queue empty counts as a failure, so rejected launches are confirmed at the engine port.

// File: rtl/dmal_pkg.sv
package dmal_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RI_SRC_ADDR = 3'd0,
    RI_DST_ADDR = 3'd1,
    RI_SRC_LEN  = 3'd2,
    RI_DST_LEN  = 3'd3,
    RI_STATUS   = 3'd4,
    RI_MASK     = 3'd5
  } reg_idx_e;

  localparam int NUM_CFG    = 4;
  localparam int NUM_STICKY = 3;
  localparam int ST_DMA     = 0;
  localparam int ST_PORT    = 1;
  localparam int ST_ERR     = 2;
  localparam int ST_BUSY    = 3;
endpackage

// File: rtl/dmal_cfg_regs.sv
module dmal_cfg_regs
  import dmal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [REG_AW-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q,
  output logic                           seq_ok
);
  // setup order tracker: 0 none, 1 src addr, 2 +dst addr, 3 +src len
  logic [1:0] step_q, step_d;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    logic              we;
    logic [DATA_W-1:0] nxt;
    always_comb begin
      we  = wr_en && (wr_addr == REG_AW'(i));
      nxt = we ? wr_data : cfg_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else        cfg_q[i] <= nxt;
    end
  end

  always_comb begin
    step_d = step_q;
    if (wr_en) begin
      unique case (wr_addr)
        RI_SRC_ADDR: step_d = 2'd1;
        RI_DST_ADDR: step_d = (step_q == 2'd1) ? 2'd2 : 2'd0;
        RI_SRC_LEN:  step_d = (step_q == 2'd2) ? 2'd3 : 2'd0;
        RI_DST_LEN:  step_d = 2'd0;
        default:     step_d = step_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 2'd0;
    else        step_q <= step_d;
  end

  assign seq_ok = (step_q == 2'd3);
endmodule

// File: rtl/dmal_launch_chk.sv
module dmal_launch_chk
  import dmal_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_LOG2 = 6
) (
  input  logic                           trig,
  input  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q,
  input  logic [DATA_W-1:0]              dst_len_new,
  input  logic                           seq_ok,
  input  logic                           busy,
  output logic                           fire,
  output logic                           reject
);
  logic [NUM_CFG-1:0][DATA_W-1:0] cand;
  logic [NUM_CFG-1:0]             lane_ok;
  logic                           aligned;

  always_comb begin
    cand                     = cfg_q;
    cand[int'(RI_DST_LEN)]   = dst_len_new;
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_align
    assign lane_ok[i] = ~|cand[i][ALIGN_LOG2-1:0];
  end

  always_comb begin
    aligned = &lane_ok;
    fire    = trig && aligned && seq_ok && !busy;
    reject  = trig && !(aligned && seq_ok && !busy);
  end
endmodule

// File: rtl/dmal_status.sv
module dmal_status
  import dmal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  logic                  reject,
  input  logic                  dma_done,
  input  logic                  port_done,
  input  logic                  clr_we,
  input  logic [NUM_STICKY-1:0] clr_bits,
  input  logic                  mask_we,
  input  logic [NUM_STICKY-1:0] mask_bits,
  output logic [NUM_STICKY-1:0] sticky_q,
  output logic [NUM_STICKY-1:0] mask_q,
  output logic                  busy,
  output logic                  start_q,
  output logic                  irq
);
  logic                  pend_dma_q, pend_dma_d;
  logic                  pend_port_q, pend_port_d;
  logic [NUM_STICKY-1:0] sticky_d, set_bits, clr_eff;
  logic [NUM_STICKY-1:0] mask_d;

  always_comb begin
    set_bits          = '0;
    set_bits[ST_DMA]  = dma_done && pend_dma_q;
    set_bits[ST_PORT] = port_done && pend_port_q;
    set_bits[ST_ERR]  = reject;
    clr_eff           = clr_we ? clr_bits : '0;
    sticky_d          = (sticky_q & ~clr_eff) | set_bits;

    pend_dma_d  = fire | (pend_dma_q & ~dma_done);
    pend_port_d = fire | (pend_port_q & ~port_done);
    mask_d      = mask_we ? mask_bits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q    <= '0;
      mask_q      <= '0;
      pend_dma_q  <= 1'b0;
      pend_port_q <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      sticky_q    <= sticky_d;
      mask_q      <= mask_d;
      pend_dma_q  <= pend_dma_d;
      pend_port_q <= pend_port_d;
      start_q     <= fire;
    end
  end

  assign busy = pend_dma_q | pend_port_q;
  assign irq  = |(sticky_q & mask_q);
endmodule

// File: rtl/dma_launch_ctrl.sv
module dma_launch_ctrl
  import dmal_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [REG_AW-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [REG_AW-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 eng_start_o,
  output logic [DATA_W-1:0]    eng_src_o,
  output logic [DATA_W-1:0]    eng_dst_o,
  output logic [DATA_W-1:0]    eng_src_len_o,
  output logic [DATA_W-1:0]    eng_dst_len_o,
  input  logic                 dma_done_i,
  input  logic                 port_done_i,
  output logic                 irq_o
);
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic                           seq_ok, trig, fire, reject, busy;
  logic [NUM_STICKY-1:0]          sticky, mask;
  logic                           clr_we, mask_we;

  assign trig    = wr_en_i && (wr_addr_i == RI_DST_LEN);
  assign clr_we  = wr_en_i && (wr_addr_i == RI_STATUS);
  assign mask_we = wr_en_i && (wr_addr_i == RI_MASK);

  dmal_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .cfg_q(cfg_q), .seq_ok(seq_ok)
  );

  dmal_launch_chk #(.DATA_W(DATA_W), .ALIGN_LOG2(ALIGN_LOG2)) u_chk_launch (
    .trig(trig), .cfg_q(cfg_q), .dst_len_new(wr_data_i), .seq_ok(seq_ok),
    .busy(busy), .fire(fire), .reject(reject)
  );

  dmal_status u_stat (
    .clk(clk), .rst_n(rst_n), .fire(fire), .reject(reject),
    .dma_done(dma_done_i), .port_done(port_done_i),
    .clr_we(clr_we), .clr_bits(wr_data_i[NUM_STICKY-1:0]),
    .mask_we(mask_we), .mask_bits(wr_data_i[NUM_STICKY-1:0]),
    .sticky_q(sticky), .mask_q(mask), .busy(busy),
    .start_q(eng_start_o), .irq(irq_o)
  );

  assign eng_src_o     = cfg_q[int'(RI_SRC_ADDR)];
  assign eng_dst_o     = cfg_q[int'(RI_DST_ADDR)];
  assign eng_src_len_o = cfg_q[int'(RI_SRC_LEN)];
  assign eng_dst_len_o = cfg_q[int'(RI_DST_LEN)];

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      RI_SRC_ADDR: rd_data_o = cfg_q[int'(RI_SRC_ADDR)];
      RI_DST_ADDR: rd_data_o = cfg_q[int'(RI_DST_ADDR)];
      RI_SRC_LEN:  rd_data_o = cfg_q[int'(RI_SRC_LEN)];
      RI_DST_LEN:  rd_data_o = cfg_q[int'(RI_DST_LEN)];
      RI_STATUS: begin
        rd_data_o[NUM_STICKY-1:0] = sticky;
        rd_data_o[ST_BUSY]        = busy;
      end
      RI_MASK:     rd_data_o[NUM_STICKY-1:0] = mask;
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/dmal_checker.sv
module dmal_checker
  import dmal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  dma_done,
  input logic                  port_done,
  input logic                  wr_en,
  input logic [REG_AW-1:0]     wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [NUM_STICKY-1:0] sticky,
  input logic                  irq
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

  assert_no_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !$past(busy));

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky[ST_ERR]) |-> $past(wr_en && wr_addr == RI_DST_LEN));

  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(dma_done || port_done));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sticky) & ~sticky) != '0) |-> $past(wr_en && wr_addr == RI_STATUS));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sticky != '0));
endmodule

bind dma_launch_ctrl dmal_checker #(.DATA_W(DATA_W)) u_dmal_checker (
  .clk(clk), .rst_n(rst_n), .start(eng_start_o), .busy(busy),
  .dma_done(dma_done_i), .port_done(port_done_i), .wr_en(wr_en_i),
  .wr_addr(wr_addr_i), .wr_data(wr_data_i), .sticky(sticky), .irq(irq_o)
);

// File: tb/sim_dma_launch_ctrl.sv
module sim_dma_launch_ctrl;
  localparam int  DW       = 32;
  localparam time CLK_HALF = 5ns;
  localparam int  WD_LIMIT = 5000;

  typedef struct packed {
    logic [DW-1:0] src, dst, slen, dlen;
  } launch_t;

  logic          clk, rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          start, dma_done, port_done, irq;
  logic [DW-1:0] e_src, e_dst, e_slen, e_dlen;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  launch_t exp_q[$];

  dma_launch_ctrl #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .eng_start_o(start), .eng_src_o(e_src), .eng_dst_o(e_dst),
    .eng_src_len_o(e_slen), .eng_dst_len_o(e_dlen),
    .dma_done_i(dma_done), .port_done_i(port_done), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic launch(input logic [DW-1:0] s, input logic [DW-1:0] d,
                        input logic [DW-1:0] sl, input logic [DW-1:0] dl, input bit good);
    launch_t item;
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, sl);
    if (good) begin
      item = '{src: s, dst: d, slen: sl, dlen: dl};
      exp_q.push_back(item);
    end
    wr(3'd3, dl);
  endtask

  task automatic pulse(input bit dd, input bit pd);
    @(negedge clk);
    dma_done = dd; port_done = pd;
    @(negedge clk);
    dma_done = 1'b0; port_done = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  // monitor: start pulses are compared against the expected launch queue
  always @(negedge clk) begin
    if (rst_n && start) begin
      launch_t got, want;
      got = '{src: e_src, dst: e_dst, slen: e_slen, dlen: e_dlen};
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R3/R4: unexpected start, actual src 0x%08h expected no start", e_src);
      end else begin
        want = exp_q.pop_front();
        chk("R2 src",  got.src,  want.src);
        chk("R2 dst",  got.dst,  want.dst);
        chk("R2 slen", got.slen, want.slen);
        chk("R2 dlen", got.dlen, want.dlen);
      end
    end
  end

  initial begin
    for (int n = 0; n < WD_LIMIT; n++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    dma_done = 1'b0; port_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_chk("R10 status", 3'd4, 32'h0);
    rd_chk("R10 src", 3'd0, 32'h0);
    chk("R10 irq", {31'd0, irq}, 32'h0);
    chk("R10 start", {31'd0, start}, 32'h0);

    // R1 readback
    wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h0000_2000); wr(3'd2, 32'h0000_0400);
    rd_chk("R1 src addr", 3'd0, 32'h0000_1000);
    rd_chk("R1 dst addr", 3'd1, 32'h0000_2000);
    rd_chk("R1 src len", 3'd2, 32'h0000_0400);

    // R2 valid launch
    launch(32'h0000_1000, 32'h0000_2000, 32'h400, 32'h400, 1'b1);
    rd_chk("R2 busy", 3'd4, 32'h8);
    rd_chk("R1 dst len", 3'd3, 32'h400);

    // R5 relaunch while busy
    launch(32'h0000_1000, 32'h0000_2000, 32'h400, 32'h400, 1'b0);
    rd_chk("R5 err while busy", 3'd4, 32'hC);

    // R7/R6 completion ordering
    pulse(1'b0, 1'b1);
    rd_chk("R7 port first busy held", 3'd4, 32'hE);
    pulse(1'b0, 1'b1);
    rd_chk("R6 repeated port done ignored", 3'd4, 32'hE);
    pulse(1'b1, 1'b0);
    rd_chk("R7 busy cleared", 3'd4, 32'h7);

    // R9 masking
    chk("R9 irq masked", {31'd0, irq}, 32'h0);
    wr(3'd5, 32'h1);
    rd_chk("R9 mask readback", 3'd5, 32'h1);
    chk("R9 irq unmasked", {31'd0, irq}, 32'h1);

    // R8 write-one-to-clear
    wr(3'd4, 32'h1);
    rd_chk("R8 clear bit0", 3'd4, 32'h6);
    chk("R9 irq after clear", {31'd0, irq}, 32'h0);
    wr(3'd4, 32'h0);
    rd_chk("R8 zero write no effect", 3'd4, 32'h6);
    wr(3'd4, 32'h6);
    rd_chk("R8 clear rest", 3'd4, 32'h0);

    // R6 done while idle ignored
    pulse(1'b1, 1'b1);
    rd_chk("R6 idle done ignored", 3'd4, 32'h0);

    // R4 misaligned address and length
    launch(32'h0000_1010, 32'h0000_2000, 32'h400, 32'h400, 1'b0);
    rd_chk("R4 misaligned addr", 3'd4, 32'h4);
    wr(3'd4, 32'h4);
    launch(32'h0000_1000, 32'h0000_2000, 32'h400, 32'h420, 1'b0);
    rd_chk("R4 misaligned dst len", 3'd4, 32'h4);
    wr(3'd4, 32'h4);

    // R3 ordering
    wr(3'd1, 32'h2000); wr(3'd0, 32'h1000); wr(3'd2, 32'h400); wr(3'd3, 32'h400);
    rd_chk("R3 swapped order", 3'd4, 32'h4);
    wr(3'd4, 32'h4);
    wr(3'd0, 32'h1000); wr(3'd2, 32'h400); wr(3'd3, 32'h400);
    rd_chk("R3 skipped register", 3'd4, 32'h4);
    wr(3'd4, 32'h4);
    wr(3'd3, 32'h400);
    rd_chk("R3 no setup", 3'd4, 32'h4);
    wr(3'd4, 32'h4);

    // R2/R7 second launch, both dones together
    launch(32'h8000_0040, 32'h0001_0000, 32'h80, 32'h80, 1'b1);
    rd_chk("R2 second busy", 3'd4, 32'h8);
    pulse(1'b1, 1'b1);
    rd_chk("R7 simultaneous done", 3'd4, 32'h3);
    wr(3'd5, 32'h4);
    chk("R9 err-only mask", {31'd0, irq}, 32'h0);
    wr(3'd5, 32'h2);
    chk("R9 port mask", {31'd0, irq}, 32'h1);

    repeat (2) @(negedge clk);
    chk("R2 all launches seen", exp_q.size(), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule